// File: doc/BRIEF.md
# Indirect Word Memory Port with Auto-Increment

This block puts a host-visible window in front of a memory of 16-bit words that has no place in the host's address map. The host has one byte-wide bus and two registers. The first is a pointer that picks a word location. The second is a data register through which the word at that pointer is read or written, one byte at a time.

Each word passes through the data register in two steps. A phase toggle tracks whether the next data access handles the low byte or the high byte. A write of the low byte is held in a latch. The whole word goes into memory when the high byte arrives. Reads present the low byte first and the high byte second. The pointer steps forward only after the high-byte access, and it wraps to zero after the last location. A host can therefore stream a block of words with a single pointer write followed by a run of data accesses.

Top module: `word_window`

## Requirements
- R1: After reset the pointer is 0 and the phase is low, so the first two data writes made without a pointer write fill word 0.
- R2: A write with `sel`=0 loads the pointer from `wdata[PTR_W-1:0]` and forces the phase to low. Cycles with neither `wr` nor `rd` change neither the pointer nor the phase.
- R3: A data write (`sel`=1) in the low phase only latches the byte. Memory is unchanged until the high-phase write, which stores {high byte, latched low byte} at the pointer.
- R4: A high-phase data access advances the pointer by one and returns the phase to low. A low-phase access leaves the pointer where it is.
- R5: In the cycle that a data read is presented, `rdata` carries bits [7:0] of the word at the pointer if the phase is low, or bits [15:8] if it is high. A read toggles the phase in the same way a write does.
- R6: The advance after a high-phase access at location DEPTH-1 sets the pointer to 0.
- R7: If `wr` and `rd` are both asserted on a data access, it is handled as a write: the byte is latched or stored, and the phase advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select: 0 pointer, 1 data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte of the word at the pointer, chosen by the phase |

## Verification
The tests stream a block of consecutive words and read it back in order. This shows whether words are assembled low-then-high and whether the pointer advances once per word rather than once per byte. A lone low-byte write followed by a pointer reload separates "latch only" from "write-through", and shows whether the phase toggle is cleared. A word written at the top location followed by a second word checks the wrap to zero. A data cycle with both strobes asserted checks that the write takes priority.

// File: rtl/word_window.sv
module word_window #(
  parameter int DEPTH = 128,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [15:0]      mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             hi;
  logic [7:0]       lat;

  wire              dacc = sel && (wr || rd);
  wire              dwr  = sel && wr;
  wire [PTR_W-1:0]  nxt  = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      hi  <= 1'b0;
      lat <= '0;
    end else if (!sel && wr) begin
      ptr <= wdata[PTR_W-1:0];
      hi  <= 1'b0;
    end else if (dacc) begin
      hi <= !hi;
      if (hi) ptr <= nxt;
      if (dwr && !hi) lat <= wdata;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && dwr && hi) mem[ptr] <= {wdata, lat};

  wire [15:0] cur = mem[ptr];
  assign rdata = hi ? cur[15:8] : cur[7:0];
endmodule

// File: rtl/word_window_chk.sv
module word_window_chk #(
  parameter int DEPTH = 128,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr,
  input logic             rd,
  input logic [7:0]       wdata,
  input logic [PTR_W-1:0] ptr,
  input logic             hi
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && wr) |=> (ptr == $past(wdata[PTR_W-1:0]) && !hi));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !rd) |=> ($stable(ptr) && $stable(hi)));

  p_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (wr || rd) && !hi) |=> (hi && $stable(ptr)));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (wr || rd) && hi && ptr != LAST) |=>
      (!hi && ptr == PTR_W'($past(ptr) + 1'b1)));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (wr || rd) && hi && ptr == LAST) |=> (!hi && ptr == '0));
endmodule

bind word_window word_window_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
  .wdata(wdata), .ptr(ptr), .hi(hi)
);

// File: tb/word_window_bench.sv
module word_window_bench;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  word_window #(.DEPTH(DEPTH)) u_word_window (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic s, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = w; rd = r; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0; rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bus(1'b0, 1'b1, 1'b0, p);
  endtask

  task automatic put_byte(input logic [7:0] b);
    bus(1'b1, 1'b1, 1'b0, b);
  endtask

  task automatic put_word(input logic [15:0] w);
    put_byte(w[7:0]);
    put_byte(w[15:8]);
  endtask

  task automatic get_byte(input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; wr = 1'b0;
    #1 check(rdata, exp, tag);
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic get_word(input logic [15:0] exp, input string tag);
    get_byte(exp[7:0], {tag, " low"});
    get_byte(exp[15:8], {tag, " high"});
  endtask

  task automatic t_reset;
    put_word(16'h1234);
    set_ptr(8'd0);
    get_word(16'h1234, "R1 word 0 after reset");
  endtask

  task automatic t_block;
    set_ptr(8'd10);
    for (int i = 0; i < 4; i++) put_word(16'hA000 + 16'(i * 16'h0101));
    set_ptr(8'd10);
    for (int i = 0; i < 4; i++) get_word(16'hA000 + 16'(i * 16'h0101), "R4 R5 block");
  endtask

  task automatic t_half;
    set_ptr(8'd20);
    put_word(16'hBEEF);
    set_ptr(8'd20);
    put_byte(8'hEE);
    set_ptr(8'd20);
    get_word(16'hBEEF, "R3 low byte only latched");
    set_ptr(8'd20);
    put_byte(8'hEE);
    set_ptr(8'd20);
    put_word(16'h2211);
    set_ptr(8'd20);
    get_word(16'h2211, "R2 phase reset by pointer write");
  endtask

  task automatic t_read_step;
    set_ptr(8'd30);
    put_word(16'h4433);
    put_word(16'h6655);
    set_ptr(8'd30);
    get_byte(8'h33, "R5 first read low");
    get_byte(8'h44, "R4 no advance after low read");
    get_byte(8'h55, "R4 advance after high read");
  endtask

  task automatic t_wrap;
    set_ptr(8'(DEPTH - 1));
    put_word(16'h7F7E);
    put_word(16'h0A0B);
    set_ptr(8'(DEPTH - 1));
    get_word(16'h7F7E, "R6 last word");
    get_word(16'h0A0B, "R6 wrapped to word 0");
  endtask

  task automatic t_prio;
    set_ptr(8'd40);
    put_word(16'h0000);
    set_ptr(8'd40);
    bus(1'b1, 1'b1, 1'b1, 8'h55);
    bus(1'b1, 1'b1, 1'b1, 8'h66);
    set_ptr(8'd40);
    get_word(16'h6655, "R7 write wins over read");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_block();
    t_half();
    t_read_step();
    t_wrap();
    t_prio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-related run hung: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule